// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block gathers eight interrupt request lines into one interrupt-pending signal for a processor. Software talks to it through a byte-wide port with two addresses. The command address takes control words and reads back the request or in-service register. The data address takes the initialisation words, then the mask register, and it always reads back the mask.

A rising edge on a request line latches a request. The block raises `intPending` while at least one request can be served. A request can be served when it is unmasked, not already in service, and of higher priority than every line now in service. Line 0 has the highest priority. When the processor pulses `ackStrobe`, the block takes the highest-priority servable line. It clears that line's request, marks it in service (unless automatic end-of-interrupt is on), and on the next cycle presents the vector (base plus line number) together with the line number for one cycle. An end-of-interrupt command, either specific or non-specific, releases a line so that lower-priority requests can get through. Special mask mode removes the priority hold-off.

Top module: `irqc_top`

## Requirements
- R1: After reset the request and in-service registers read as 0x00, the mask register reads as 0xFF and `intPending` is low.
- R2: A line that goes high sets its request bit at the next clock edge. A line that goes low clears its request bit. A line held high after its acknowledge does not request again until it falls and rises.
- R3: A command write with bit 4 set starts initialisation, where bit 1 = single mode and bit 0 = fourth word wanted. The data writes that follow are taken in this order: base word (low three bits forced to zero), cascade word (left out in single mode), mode word (only if wanted). Every data write after the sequence goes to the mask.
- R4: A data write outside initialisation loads the mask register, and a data read returns it. A masked request is held in the request register but never raises `intPending`.
- R5: `intPending` is high exactly when some request is unmasked, not in service, and numbered below the lowest-numbered in-service line. Of the lines that qualify, an acknowledge takes the lowest-numbered one.
- R6: A command write with bits 4:3 = 01 and bit 6 set puts special mask mode on (bit 5 = 1) or off (bit 5 = 0). While special mask mode is on, the in-service priority condition of R5 does not apply.
- R7: One cycle after an `ackStrobe` that finds a servable line, `vecValid` is high for one cycle, with `vecOut` = base OR line and `ackLine` = line. The line's request bit is cleared and its in-service bit is set. An acknowledge with no servable line produces no `vecValid`.
- R8: Mode-word bit 1 enables automatic end-of-interrupt. In that mode an acknowledge clears the request but leaves the in-service bit clear.
- R9: A command write with bits 4:3 = 00 and bits 6:5 = 11 clears the in-service bit numbered by bits 2:0.
- R10: A command write with bits 4:3 = 00 and bits 6:5 = 01 clears the lowest-numbered in-service bit. When nothing is in service it changes nothing.
- R11: A command write with bits 4:3 = 01 and bit 1 set selects what command reads return: bit 0 = 1 selects the in-service register, bit 0 = 0 selects the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register port |
| addrSel | input | 1 | 0 = command address, 1 = data address |
| wrData | input | NUM_LINES | Write data |
| rdData | output | NUM_LINES | Read data (combinational from addrSel) |
| irqLines | input | NUM_LINES | Request lines, bit n = line n |
| intPending | output | 1 | A servable request exists |
| ackStrobe | input | 1 | Processor acknowledge pulse |
| vecValid | output | 1 | Vector and line valid for this cycle |
| vecOut | output | NUM_LINES | Vector = base OR line |
| ackLine | output | IDX_W | Line number that was acknowledged |

## Verification
The bench builds the block with the default NUM_LINES = 8. At that width every line number fits into the three bits that the base word leaves zero. The command bit positions at 3 to 6 also fall inside the byte, so the whole command set can be driven.

With this configuration the bench walks through the cases that matter:
- a cascaded setup with a mode word, and the two single-mode sequences;
- nested service, with higher lines cutting in and lower lines held off;
- release by specific and by non-specific end-of-interrupt, including a non-specific one with nothing in service;
- special mask mode;
- automatic end-of-interrupt ordering;
- an acknowledge that finds nothing to serve.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQC_LINES = 8;
  localparam int IRQC_IDX_W = $clog2(IRQC_LINES);

  typedef enum logic [1:0] {
    STEP_MASK = 2'd0,
    STEP_BASE = 2'd1,
    STEP_CASC = 2'd2,
    STEP_MODE = 2'd3
  } initStep_t;

  typedef struct packed {
    logic maskWr;
    logic baseWr;
    logic eoiSpec;
    logic eoiNonSpec;
    logic [IRQC_IDX_W-1:0] eoiLine;
  } ctrlStrobes_t;

  typedef struct packed {
    logic specialMask;
    logic autoEoi;
    logic readIsr;
  } ctrlModes_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrEn,
  input  logic         addrSel,
  input  logic [6:0]   ctlBits,
  output ctrlStrobes_t strobes,
  output ctrlModes_t   modes
);
  initStep_t step;
  logic singleMode;
  logic wantModeWord;

  logic cmdWr, dataWr, isInit, isSel, isEoi;
  assign cmdWr  = wrEn & ~addrSel;
  assign dataWr = wrEn & addrSel;
  assign isInit = cmdWr & ctlBits[4];
  assign isSel  = cmdWr & ~ctlBits[4] & ctlBits[3];
  assign isEoi  = cmdWr & ~ctlBits[4] & ~ctlBits[3] & ctlBits[5];

  always_comb begin
    strobes.maskWr     = dataWr && (step == STEP_MASK);
    strobes.baseWr     = dataWr && (step == STEP_BASE);
    strobes.eoiSpec    = isEoi & ctlBits[6];
    strobes.eoiNonSpec = isEoi & ~ctlBits[6];
    strobes.eoiLine    = ctlBits[IRQC_IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step         <= STEP_MASK;
      singleMode   <= 1'b0;
      wantModeWord <= 1'b0;
      modes        <= '0;
    end else begin
      if (isInit) begin
        singleMode   <= ctlBits[1];
        wantModeWord <= ctlBits[0];
        step         <= STEP_BASE;
      end else if (dataWr) begin
        case (step)
          STEP_BASE: begin
            if (!singleMode)       step <= STEP_CASC;
            else if (wantModeWord) step <= STEP_MODE;
            else                   step <= STEP_MASK;
          end
          STEP_CASC: step <= wantModeWord ? STEP_MODE : STEP_MASK;
          STEP_MODE: begin
            modes.autoEoi <= ctlBits[1];
            step          <= STEP_MASK;
          end
          default: step <= STEP_MASK;
        endcase
      end
      if (isSel) begin
        if (ctlBits[1]) modes.readIsr     <= ctlBits[0];
        if (ctlBits[6]) modes.specialMask <= ctlBits[5];
      end
    end
  end
endmodule

// File: rtl/irqc_dpath.sv
module irqc_dpath
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = IRQC_LINES,
  localparam int IDX_W = $clog2(NUM_LINES)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 ackStrobe,
  input  logic [NUM_LINES-1:0] wrByte,
  input  ctrlStrobes_t         strobes,
  input  ctrlModes_t           modes,
  output logic [NUM_LINES-1:0] irrQ,
  output logic [NUM_LINES-1:0] isrQ,
  output logic [NUM_LINES-1:0] imrQ,
  output logic                 intPending,
  output logic                 vecValid,
  output logic [NUM_LINES-1:0] vecOut,
  output logic [IDX_W-1:0]     ackLine
);
  logic [NUM_LINES-1:0] linesPrev;
  logic [NUM_LINES-1:0] baseQ;
  logic [NUM_LINES-1:0] prioMask, eligible, ackOneHot, eoiClr;
  logic [IDX_W-1:0]     selLine;

  // lines strictly above the lowest-numbered in-service line
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      seen        = seen | isrQ[i];
      prioMask[i] = ~seen;
    end
  end

  assign eligible   = irrQ & ~imrQ & ~isrQ &
                      (modes.specialMask ? {NUM_LINES{1'b1}} : prioMask);
  assign intPending = |eligible;

  always_comb begin
    selLine = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (eligible[i]) selLine = IDX_W'(i);
  end

  assign ackOneHot = (ackStrobe && intPending) ? (NUM_LINES'(1) << selLine) : '0;

  always_comb begin
    eoiClr = '0;
    if (strobes.eoiSpec)         eoiClr = NUM_LINES'(1) << strobes.eoiLine;
    else if (strobes.eoiNonSpec) eoiClr = isrQ & (~isrQ + NUM_LINES'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      linesPrev <= '0;
      irrQ      <= '0;
      isrQ      <= '0;
      imrQ      <= '1;
      baseQ     <= '0;
      vecValid  <= 1'b0;
      vecOut    <= '0;
      ackLine   <= '0;
    end else begin
      linesPrev <= irqLines;
      irrQ      <= ((irrQ & ~ackOneHot) | (irqLines & ~linesPrev)) & irqLines;
      isrQ      <= (isrQ & ~eoiClr) | (modes.autoEoi ? '0 : ackOneHot);
      if (strobes.maskWr) imrQ  <= wrByte;
      if (strobes.baseWr) baseQ <= {wrByte[NUM_LINES-1:IDX_W], {IDX_W{1'b0}}};
      vecValid <= |ackOneHot;
      if (|ackOneHot) begin
        vecOut  <= baseQ | NUM_LINES'(selLine);
        ackLine <= selLine;
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = IRQC_LINES,
  localparam int IDX_W = $clog2(NUM_LINES)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic                 addrSel,
  input  logic [NUM_LINES-1:0] wrData,
  output logic [NUM_LINES-1:0] rdData,
  input  logic [NUM_LINES-1:0] irqLines,
  output logic                 intPending,
  input  logic                 ackStrobe,
  output logic                 vecValid,
  output logic [NUM_LINES-1:0] vecOut,
  output logic [IDX_W-1:0]     ackLine
);
  ctrlStrobes_t strobes;
  ctrlModes_t   modes;
  logic [NUM_LINES-1:0] irrQ, isrQ, imrQ;
  logic autoEoiMode;

  assign autoEoiMode = modes.autoEoi;

  irqc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addrSel(addrSel),
    .ctlBits(wrData[6:0]), .strobes(strobes), .modes(modes)
  );

  irqc_dpath #(.NUM_LINES(NUM_LINES)) u_dpath (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines), .ackStrobe(ackStrobe),
    .wrByte(wrData), .strobes(strobes), .modes(modes),
    .irrQ(irrQ), .isrQ(isrQ), .imrQ(imrQ), .intPending(intPending),
    .vecValid(vecValid), .vecOut(vecOut), .ackLine(ackLine)
  );

  assign rdData = addrSel ? imrQ : (modes.readIsr ? isrQ : irrQ);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
)(
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     irrQ,
  input logic [W-1:0]     isrQ,
  input logic [W-1:0]     imrQ,
  input logic             intPending,
  input logic             ackStrobe,
  input logic             vecValid,
  input logic [W-1:0]     vecOut,
  input logic [IDX_W-1:0] ackLine,
  input logic             autoEoiMode
);
  a_r4_pend_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    intPending |-> ((irrQ & ~imrQ & ~isrQ) != '0));

  a_r7_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> $past(ackStrobe));

  a_r7_vec_line: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> (vecOut[IDX_W-1:0] == ackLine));

  a_r7_irr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> !irrQ[ackLine]);

  a_r7_isr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && !$past(autoEoiMode)) |-> isrQ[ackLine]);

  a_r8_auto_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && $past(autoEoiMode)) |-> !isrQ[ackLine]);
endmodule

bind irqc_top irqc_checker #(.W(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irrQ(irrQ), .isrQ(isrQ), .imrQ(imrQ),
  .intPending(intPending), .ackStrobe(ackStrobe), .vecValid(vecValid),
  .vecOut(vecOut), .ackLine(ackLine), .autoEoiMode(autoEoiMode)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic addrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] irqLines = '0;
  logic intPending;
  logic ackStrobe = 1'b0;
  logic vecValid;
  logic [7:0] vecOut;
  logic [2:0] ackLine;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [10:0] expQ[$];

  always #5 clk = ~clk;

  irqc_top uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    @(negedge clk); wrEn = 1'b1; addrSel = sel; wrData = v;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk); addrSel = sel; #1 v = rdData;
  endtask

  task automatic setLines(input logic [7:0] v);
    @(negedge clk); irqLines = v;
    @(negedge clk);
  endtask

  // driver: push the expected vector/line, then pulse acknowledge
  task automatic doAck(input bit expect_, input logic [7:0] base, input int line);
    @(negedge clk);
    if (expect_) expQ.push_back({base | 8'(line), 3'(line)});
    ackStrobe = 1'b1;
    @(negedge clk); ackStrobe = 1'b0;
    if (!expect_) check("R7 no vector on empty ack", vecValid, 0);
  endtask

  // monitor: compare produced vectors against the scoreboard
  always @(negedge clk) begin
    if (rst_n && vecValid) begin
      if (expQ.size() == 0) check("R7 unexpected vector", {vecOut, ackLine}, 0);
      else check("R7 vector/line", {vecOut, ackLine}, expQ.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(1'b0, v); check("R1 request reg", v, 8'h00);
    rd(1'b1, v); check("R1 mask reg", v, 8'hFF);
    check("R1 pending", intPending, 0);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R1 in-service reg", v, 8'h00);
    wr(1'b0, 8'h0A);
    // R3: cascaded, mode word wanted
    wr(1'b0, 8'h11); wr(1'b1, 8'h45); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    wr(1'b1, 8'hF0);
    rd(1'b1, v); check("R3/R4 mask after full sequence", v, 8'hF0);
    // R4 / R2: masked line latched, no pending; drop clears
    setLines(8'h20);
    rd(1'b0, v); check("R2 rising edge latched", v, 8'h20);
    check("R4 masked holds off", intPending, 0);
    setLines(8'h00);
    rd(1'b0, v); check("R2 drop clears request", v, 8'h00);
    // R5 / R7
    setLines(8'h0A);
    check("R5 pending", intPending, 1);
    doAck(1, 8'h40, 1);
    rd(1'b0, v); check("R7 request bit cleared", v, 8'h08);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R11/R7 in-service set", v, 8'h02);
    check("R5 lower line held off", intPending, 0);
    setLines(8'h0B);
    check("R5 higher line cuts in", intPending, 1);
    doAck(1, 8'h40, 0);
    rd(1'b0, v); check("R7 nested in-service", v, 8'h03);
    // R10
    wr(1'b0, 8'h20);
    rd(1'b0, v); check("R10 non-specific clears lowest", v, 8'h02);
    check("R5 still held", intPending, 0);
    // R6
    wr(1'b0, 8'h68); check("R6 special mask on", intPending, 1);
    wr(1'b0, 8'h48); check("R6 special mask off", intPending, 0);
    // R9
    wr(1'b0, 8'h61);
    rd(1'b0, v); check("R9 specific EOI", v, 8'h00);
    check("R9 line 3 released", intPending, 1);
    doAck(1, 8'h40, 3);
    rd(1'b0, v); check("R7 in-service line 3", v, 8'h08);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); check("R2 held line no re-request", v, 8'h00);
    wr(1'b0, 8'h20); wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R10 clears last", v, 8'h00);
    wr(1'b0, 8'h20);
    rd(1'b0, v); check("R10 ignored when empty", v, 8'h00);
    check("R10 no pending after empty EOI", intPending, 0);
    setLines(8'h00);
    // R3: single mode, no mode word
    wr(1'b0, 8'h12); wr(1'b1, 8'h9B); wr(1'b1, 8'hFE);
    rd(1'b1, v); check("R3 single skips words", v, 8'hFE);
    // R8: single with mode word, auto EOI
    wr(1'b0, 8'h13); wr(1'b1, 8'h20); wr(1'b1, 8'h03); wr(1'b1, 8'h00);
    rd(1'b1, v); check("R3 single with mode word", v, 8'h00);
    setLines(8'h40);
    doAck(1, 8'h20, 6);
    rd(1'b0, v); check("R8 auto EOI no in-service", v, 8'h00);
    check("R8 pending clear", intPending, 0);
    setLines(8'h00);
    setLines(8'h84);
    doAck(1, 8'h20, 2);
    check("R5 next line pending", intPending, 1);
    doAck(1, 8'h20, 7);
    doAck(0, 8'h00, 0);
    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", expQ.size(), 0);
    finish_run();
  end
endmodule